// File: doc/BRIEF.md
# Chained Two-Segment DMA Channel

This block is a single DMA channel. It moves words between a peripheral data port and memory. The channel holds two buffer descriptions at once. The active segment is a running address and an end address. The queued segment is a start and a stop address that software loads ahead of time. When the running address reaches its end, the channel either takes over the queued segment at once or stops. The choice depends on a flag that software arms. Because of this, a chain of buffers can run back to back, and software does not need to respond within one word time.

Software drives the channel through a small register bus. One command/status register accepts write-one command bits and returns separate enable, chain-armed, complete, bus-fault and direction flags. These flags let an interrupt handler tell a chained hand-over from a final stop. The interrupt output follows the complete flag. Every address register also has a shadow copy that only software changes, so software can record the original segment values.

Top module: `dma_chain_chan`

## Requirements
- R1: The registers at word offsets 1 to 8 (running address, end address, queued start, queued stop, then four shadow registers) each read back exactly the value last written. The channel itself never changes the four shadow registers.
- R2: Offset 0 takes command bits: bit0 reset, bit1 clear-complete, bit2 set-enable, bit3 arm-chain, bit4 select memory-read direction, bit5 select memory-write direction. Offset 0 reads status: bit0 enable, bit1 chain-armed, bit2 complete, bit3 bus-fault, bit4 direction (1 = memory to peripheral). After reset, or after a write of reset together with clear-complete, enable, chain-armed, complete and bus-fault all read 0.
- R3: Each word moves through one memory access at the running address. The running address then advances by 4. In the memory-write direction, the peripheral word is stored. In the memory-read direction, the memory word is presented on `per_wdata` together with `per_ack`.
- R4: When the running address equals the end address and chain is armed, the queued start and stop load into the running and end registers. Complete is then set, chain-armed is cleared, enable stays set, and transfers continue.
- R5: When the running address equals the end address and chain is not armed, complete is set and enable is cleared. No further memory request is made, and the running and end registers both hold the final address.
- R6: `irq` is high exactly while complete is set, and a clear-complete command lowers it.
- R7: A memory access answered with `mem_err` sets bus-fault and complete and clears enable. The running address is not advanced past the faulting word.
- R8: A segment whose running and end addresses are equal when enabled completes without any memory access.
- R9: The direction selected by command bits 4 and 5 sets whether memory is written or read, and it is reported in status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset for a write and for the registered read |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Read data for the offset seen on the previous clock |
| irq | output | 1 | Segment-complete interrupt |
| mem_req | output | 1 | Memory request, held until it is answered |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory access done |
| mem_err | input | 1 | Memory access failed |
| per_req | input | 1 | Peripheral ready to give or take a word |
| per_rdata | input | DW | Word from the peripheral |
| per_ack | output | 1 | One-cycle pulse: one word consumed or delivered |
| per_wdata | output | DW | Word to the peripheral, valid with `per_ack` |

## Verification
A register read returns data on the clock after its offset is presented. The bench therefore drives the offset on one falling edge and samples on the next. With a one-cycle memory answer, each word takes two clocks. `per_ack` rises on the edge after `mem_ack` is seen, and the running address moves on that same edge. Complete, and with it `irq`, rises on the edge that detects the end of a segment. Because every result lands on a known edge, the bench samples only on falling edges. It waits for `irq` before reading status, and it makes each chained segment long enough that the flags are still in their mid-chain state when they are read.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  localparam int REG_AW = 4;
  localparam int CMD_W  = 6;
  localparam int STAT_W = 5;

  // register word offsets
  localparam logic [REG_AW-1:0] RA_CTRL   = 4'd0;
  localparam logic [REG_AW-1:0] RA_NEXT   = 4'd1;
  localparam logic [REG_AW-1:0] RA_LIMIT  = 4'd2;
  localparam logic [REG_AW-1:0] RA_START  = 4'd3;
  localparam logic [REG_AW-1:0] RA_STOP   = 4'd4;
  localparam logic [REG_AW-1:0] RA_SHADOW = 4'd5;
  localparam int                N_SHADOW  = 4;

  // command bits (write-one)
  localparam int CB_RESET   = 0;
  localparam int CB_CLRDONE = 1;
  localparam int CB_SETEN   = 2;
  localparam int CB_ARM     = 3;
  localparam int CB_DIRRD   = 4;
  localparam int CB_DIRWR   = 5;

  typedef enum logic {XS_IDLE, XS_BUSY} xfer_state_t;

endpackage

// File: rtl/dma_chain_segregs.sv
module dma_chain_segregs
  import dma_chain_pkg::*;
#(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we,
  input  logic [REG_AW-1:0] sw_addr,
  input  logic [AW-1:0]     sw_wdata,
  input  logic              adv,
  input  logic              chain,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [AW-1:0]     rd_val,
  output logic [AW-1:0]     next_q,
  output logic [AW-1:0]     limit_q
);

  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic [AW-1:0] start_q, stop_q;
  logic [AW-1:0] sh_val [N_SHADOW];

  wire wr_next  = sw_we && (sw_addr == RA_NEXT);
  wire wr_limit = sw_we && (sw_addr == RA_LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      next_q  <= '0;
      limit_q <= '0;
      start_q <= '0;
      stop_q  <= '0;
    end else begin
      if (wr_next)    next_q <= sw_wdata;
      else if (chain) next_q <= start_q;
      else if (adv)   next_q <= next_q + STEP_V;

      if (wr_limit)   limit_q <= sw_wdata;
      else if (chain) limit_q <= stop_q;

      if (sw_we && sw_addr == RA_START) start_q <= sw_wdata;
      if (sw_we && sw_addr == RA_STOP)  stop_q  <= sw_wdata;
    end
  end

  // software-only shadow copies
  for (genvar g = 0; g < N_SHADOW; g++) begin : g_shadow
    localparam logic [REG_AW-1:0] MY_ADDR = REG_AW'(int'(RA_SHADOW) + g);
    logic [AW-1:0] val_q;
    always_ff @(posedge clk) begin
      if (rst)                             val_q <= '0;
      else if (sw_we && sw_addr == MY_ADDR) val_q <= sw_wdata;
    end
    assign sh_val[g] = val_q;
  end

  always_comb begin
    case (rd_addr)
      RA_NEXT:  rd_val = next_q;
      RA_LIMIT: rd_val = limit_q;
      RA_START: rd_val = start_q;
      RA_STOP:  rd_val = stop_q;
      4'd5:     rd_val = sh_val[0];
      4'd6:     rd_val = sh_val[1];
      4'd7:     rd_val = sh_val[2];
      4'd8:     rd_val = sh_val[3];
      default:  rd_val = '0;
    endcase
  end

  // R3: a completed word moves the running address by one word
  p_advance_step_r3: assert property (@(posedge clk) disable iff (rst)
    (adv && !chain && !wr_next) |=> (next_q == $past(next_q) + STEP_V));

  // R4: chaining copies the queued pair into the active pair
  p_chain_load_r4: assert property (@(posedge clk) disable iff (rst)
    (chain && !sw_we) |=> (next_q == $past(start_q) && limit_q == $past(stop_q)));

endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dma_chain_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             any_we,
  input  logic             ctrl_we,
  input  logic [CMD_W-1:0] cmd,
  input  logic [AW-1:0]    next_q,
  input  logic [AW-1:0]    limit_q,
  input  logic             mem_ack,
  input  logic             mem_err,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             per_req,
  input  logic [DW-1:0]    per_rdata,
  output logic             adv,
  output logic             chain,
  output logic             en_q,
  output logic             upd_q,
  output logic             done_q,
  output logic             berr_q,
  output logic             dir_q,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             per_ack,
  output logic [DW-1:0]    per_wdata
);

  xfer_state_t state_q;

  wire at_limit  = (next_q == limit_q);
  wire can_act   = en_q && (state_q == XS_IDLE) && !any_we;
  wire boundary  = can_act && at_limit;
  wire issue     = can_act && !at_limit && per_req;
  wire busy      = (state_q == XS_BUSY);
  wire bus_fault = busy && mem_err;

  assign chain = boundary && upd_q;
  assign adv   = busy && mem_ack && !mem_err;

  // status flags: software commands first, hardware events override
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      upd_q  <= 1'b0;
      done_q <= 1'b0;
      berr_q <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      if (ctrl_we) begin
        if (cmd[CB_RESET]) begin
          en_q   <= 1'b0;
          upd_q  <= 1'b0;
          done_q <= 1'b0;
          berr_q <= 1'b0;
        end else begin
          if (cmd[CB_SETEN]) en_q  <= 1'b1;
          if (cmd[CB_ARM])   upd_q <= 1'b1;
        end
        if (cmd[CB_CLRDONE]) done_q <= 1'b0;
        if (cmd[CB_DIRRD])      dir_q <= 1'b1;
        else if (cmd[CB_DIRWR]) dir_q <= 1'b0;
      end
      if (boundary) begin
        done_q <= 1'b1;
        if (upd_q) upd_q <= 1'b0;
        else       en_q  <= 1'b0;
      end
      if (bus_fault) begin
        berr_q <= 1'b1;
        done_q <= 1'b1;
        en_q   <= 1'b0;
      end
    end
  end

  // word mover
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= XS_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      per_ack   <= 1'b0;
      per_wdata <= '0;
    end else begin
      per_ack <= 1'b0;
      case (state_q)
        XS_IDLE: begin
          if (issue) begin
            mem_req   <= 1'b1;
            mem_addr  <= next_q;
            mem_we    <= ~dir_q;
            mem_wdata <= per_rdata;
            state_q   <= XS_BUSY;
          end
        end
        XS_BUSY: begin
          if (mem_err) begin
            mem_req <= 1'b0;
            state_q <= XS_IDLE;
          end else if (mem_ack) begin
            mem_req   <= 1'b0;
            per_ack   <= 1'b1;
            per_wdata <= mem_rdata;
            state_q   <= XS_IDLE;
          end
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  // R4: hand-over keeps the channel running and disarms the chain flag
  p_chain_keeps_en_r4: assert property (@(posedge clk) disable iff (rst)
    (boundary && upd_q) |=> (en_q && !upd_q && done_q));

  // R5: end without a queued segment stops the channel
  p_shutdown_r5: assert property (@(posedge clk) disable iff (rst)
    (boundary && !upd_q) |=> (!en_q && done_q));

  // R5: no new request once disabled
  p_no_issue_off_r5: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !$rose(mem_req));

  // R2: reset plus clear-complete leaves the flags at zero
  p_reset_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && cmd[CB_RESET] && cmd[CB_CLRDONE] && !bus_fault)
      |=> (!en_q && !upd_q && !done_q && !berr_q));

  // R7: a fault stops the channel and is reported
  p_fault_stops_r7: assert property (@(posedge clk) disable iff (rst)
    bus_fault |=> (!en_q && berr_q && done_q));

  // R3: a pending request holds its address until answered
  p_req_held_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack && !mem_err) |=> (mem_req && $stable(mem_addr)));

endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
  import dma_chain_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [AW-1:0]     reg_wdata,
  output logic [AW-1:0]     reg_rdata,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic              per_req,
  input  logic [DW-1:0]     per_rdata,
  output logic              per_ack,
  output logic [DW-1:0]     per_wdata
);

  localparam int STEP = DW / 8;

  logic [AW-1:0] next_q, limit_q, seg_rd;
  logic adv, chain, en_q, upd_q, done_q, berr_q, dir_q;
  logic [STAT_W-1:0] status;

  wire ctrl_we = reg_we && (reg_addr == RA_CTRL);

  dma_chain_segregs #(.AW(AW), .STEP(STEP)) u_seg (
    .clk      (clk),
    .rst      (rst),
    .sw_we    (reg_we),
    .sw_addr  (reg_addr),
    .sw_wdata (reg_wdata),
    .adv      (adv),
    .chain    (chain),
    .rd_addr  (reg_addr),
    .rd_val   (seg_rd),
    .next_q   (next_q),
    .limit_q  (limit_q)
  );

  dma_chain_engine #(.AW(AW), .DW(DW)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .any_we    (reg_we),
    .ctrl_we   (ctrl_we),
    .cmd       (reg_wdata[CMD_W-1:0]),
    .next_q    (next_q),
    .limit_q   (limit_q),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .mem_rdata (mem_rdata),
    .per_req   (per_req),
    .per_rdata (per_rdata),
    .adv       (adv),
    .chain     (chain),
    .en_q      (en_q),
    .upd_q     (upd_q),
    .done_q    (done_q),
    .berr_q    (berr_q),
    .dir_q     (dir_q),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .per_ack   (per_ack),
    .per_wdata (per_wdata)
  );

  assign status = {dir_q, berr_q, done_q, upd_q, en_q};
  assign irq    = done_q;

  always_ff @(posedge clk) begin
    if (rst)                     reg_rdata <= '0;
    else if (reg_addr == RA_CTRL) reg_rdata <= {{(AW-STAT_W){1'b0}}, status};
    else                         reg_rdata <= seg_rd;
  end

  // R6: interrupt falls on the edge after a clear-complete with no fault
  p_irq_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && reg_wdata[CB_CLRDONE] && !(mem_req && mem_err)) |=> !irq);

endmodule

// File: tb/dma_chain_chan_tb.sv
`timescale 1ns/1ps
module dma_chain_chan_tb;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [31:0] C_RST = 32'h01, C_CLR = 32'h02, C_EN = 32'h04,
                          C_ARM = 32'h08, C_RD  = 32'h10, C_WR = 32'h20;
  localparam logic [31:0] S_EN = 32'h01, S_UPD = 32'h02, S_DONE = 32'h04,
                          S_BERR = 32'h08, S_DIR = 32'h10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic irq, mem_req, mem_we, per_ack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, per_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic mem_ack = 1'b0, mem_err = 1'b0;
  logic per_req = 1'b0;
  logic [DW-1:0] per_rdata = '0;

  logic [31:0] mem [256];
  logic [31:0] got_rd [64];
  int rd_idx = 0;
  int req_cnt = 0;
  logic err_en = 1'b0;
  logic [31:0] err_addr = '0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_chain_chan #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .per_req(per_req), .per_rdata(per_rdata),
    .per_ack(per_ack), .per_wdata(per_wdata)
  );

  // memory and peripheral models, acting on falling edges
  always @(negedge clk) begin
    mem_ack <= 1'b0;
    mem_err <= 1'b0;
    if (mem_req && !mem_ack && !mem_err) begin
      req_cnt <= req_cnt + 1;
      if (err_en && mem_addr == err_addr) mem_err <= 1'b1;
      else begin
        mem_ack <= 1'b1;
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[9:2]];
      end
    end
    if (per_ack) begin
      per_rdata <= per_rdata + 1;
      if (rd_idx < 64) got_rd[rd_idx] <= per_wdata;
      rd_idx <= rd_idx + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_irq(input string req);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq) return;
    end
    chk({req, " irq timeout"}, 32'd0, 32'd1);
  endtask

  task automatic setseg(input logic [31:0] n, input logic [31:0] l,
                        input logic [31:0] s, input logic [31:0] p);
    wr(4'd1, n); wr(4'd2, l); wr(4'd3, s); wr(4'd4, p);
  endtask

  function automatic logic [31:0] pat(input int a, input int p);
    return 32'h1357_9BDF * (a + 1) + 32'h0F0F_1234 * p + (p == 1 ? 32'hFFFF_0000 : 32'h0);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(4'd0, v); chk("R2 status after reset", v, 32'h0);
    chk("R6 irq after reset", {31'b0, irq}, 32'h0);
    rd(4'd1, v); chk("R1 running addr after reset", v, 32'h0);

    // register readback sweep, channel disabled
    for (int p = 0; p < 4; p++) begin
      for (int a = 1; a <= 8; a++) wr(4'(a), pat(a, p));
      for (int a = 1; a <= 8; a++) begin
        rd(4'(a), v);
        chk($sformatf("R1 readback off %0d pat %0d", a, p), v, pat(a, p));
      end
    end
    wr(4'd0, C_RST | C_CLR | C_WR);

    // single segment, memory-write direction, shutdown
    per_req = 1'b1;
    per_rdata = 32'h100;
    req_cnt = 0;
    setseg(32'h40, 32'h50, 32'h0, 32'h0);
    wr(4'd0, C_EN | C_WR);
    wait_irq("R5");
    rd(4'd0, v); chk("R5 status after shutdown", v, S_DONE);
    rd(4'd1, v); chk("R5 running addr final", v, 32'h50);
    rd(4'd2, v); chk("R5 end addr final", v, 32'h50);
    for (int i = 0; i < 4; i++)
      chk($sformatf("R3 stored word %0d", i), mem[16 + i], 32'h100 + i);
    repeat (10) @(negedge clk);
    chk("R5 no request after stop", req_cnt, 32'd4);
    chk("R6 irq high while complete", {31'b0, irq}, 32'h1);
    for (int a = 5; a <= 8; a++) begin
      rd(4'(a), v); chk($sformatf("R1 shadow %0d untouched", a), v, pat(a, 3));
    end
    wr(4'd0, C_CLR | C_WR);
    chk("R6 irq cleared", {31'b0, irq}, 32'h0);

    // two chained segments
    per_rdata = 32'h200;
    req_cnt = 0;
    setseg(32'h80, 32'h88, 32'hC0, 32'hE0);
    wr(4'd0, C_EN | C_ARM | C_WR);
    wait_irq("R4");
    rd(4'd0, v); chk("R4 status mid-chain", v, S_EN | S_DONE);
    rd(4'd2, v); chk("R4 end addr from queued stop", v, 32'hE0);
    wr(4'd0, C_CLR | C_WR);
    chk("R6 irq cleared mid-chain", {31'b0, irq}, 32'h0);
    wait_irq("R4");
    rd(4'd0, v); chk("R5 status after chained stop", v, S_DONE);
    chk("R3 chain word 0", mem[32], 32'h200);
    chk("R3 chain word 1", mem[33], 32'h201);
    for (int i = 0; i < 8; i++)
      chk($sformatf("R4 second segment word %0d", i), mem[48 + i], 32'h202 + i);
    chk("R4 request count", req_cnt, 32'd10);
    wr(4'd0, C_CLR | C_WR);

    // three segments with servicing between
    per_rdata = 32'h300;
    req_cnt = 0;
    setseg(32'h100, 32'h108, 32'h120, 32'h160);
    wr(4'd0, C_EN | C_ARM | C_WR);
    wait_irq("R4");
    wr(4'd3, 32'h180);
    wr(4'd4, 32'h1A0);
    wr(4'd0, C_CLR | C_ARM | C_WR);
    rd(4'd0, v); chk("R4 rearmed status", v, S_EN | S_UPD);
    wait_irq("R4");
    rd(4'd0, v); chk("R4 second hand-over status", v, S_EN | S_DONE);
    wr(4'd0, C_CLR | C_WR);
    wait_irq("R4");
    rd(4'd0, v); chk("R5 status after third segment", v, S_DONE);
    rd(4'd1, v); chk("R5 final running addr", v, 32'h1A0);
    chk("R4 last stored word", mem[32'h19C >> 2], 32'h300 + 25);
    chk("R4 first word of second segment", mem[32'h120 >> 2], 32'h302);
    chk("R4 three-segment request count", req_cnt, 32'd26);
    wr(4'd0, C_CLR | C_WR);

    // memory-read direction
    for (int i = 0; i < 256; i++) mem[i] = 32'hC000_0000 + i;
    rd_idx = 0;
    req_cnt = 0;
    setseg(32'h200, 32'h210, 32'h0, 32'h0);
    wr(4'd0, C_EN | C_RD);
    wait_irq("R9");
    rd(4'd0, v); chk("R9 status read direction", v, S_DONE | S_DIR);
    chk("R3 words delivered", rd_idx, 32'd4);
    for (int i = 0; i < 4; i++)
      chk($sformatf("R3 word to peripheral %0d", i), got_rd[i], 32'hC000_0080 + i);
    chk("R9 memory unchanged on read", mem[32'h80], 32'hC000_0080);

    // bus fault
    wr(4'd0, C_RST | C_CLR | C_WR);
    err_en = 1'b1;
    err_addr = 32'h308;
    req_cnt = 0;
    setseg(32'h300, 32'h320, 32'h0, 32'h0);
    wr(4'd0, C_EN | C_WR);
    wait_irq("R7");
    rd(4'd0, v); chk("R7 status after fault", v, S_BERR | S_DONE);
    rd(4'd1, v); chk("R7 running addr held at fault", v, 32'h308);
    repeat (6) @(negedge clk);
    chk("R7 request count", req_cnt, 32'd3);
    wr(4'd0, C_RST | C_CLR);
    rd(4'd0, v); chk("R2 reset clears fault status", v, 32'h0);
    chk("R6 irq low after reset", {31'b0, irq}, 32'h0);
    err_en = 1'b0;

    // zero-length segment
    req_cnt = 0;
    setseg(32'h3C0, 32'h3C0, 32'h0, 32'h0);
    wr(4'd0, C_EN | C_WR);
    wait_irq("R8");
    rd(4'd0, v); chk("R8 zero-length status", v, S_DONE);
    repeat (4) @(negedge clk);
    chk("R8 no memory access", req_cnt, 32'd0);

    // reset during an armed, running transfer
    wr(4'd0, C_CLR);
    setseg(32'h000, 32'h100, 32'h100, 32'h200);
    wr(4'd0, C_EN | C_ARM | C_WR);
    repeat (5) @(negedge clk);
    wr(4'd0, C_RST | C_CLR);
    rd(4'd0, v); chk("R2 reset mid-transfer status", v, 32'h0);
    chk("R6 irq after mid reset", {31'b0, irq}, 32'h0);
    req_cnt = 0;
    repeat (8) @(negedge clk);
    chk("R2 no requests after reset", req_cnt, 32'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule